// File: doc/BRIEF.md
# Overhead Byte Serial Output Port

This block receives a byte-wide stream from the receive side of an STS-12/STM-4 framer and sends every transport overhead byte out, one bit at a time, on a dedicated serial port. Each input byte comes with a qualifier `in_valid`. It also carries a flag `in_toh` that marks it as overhead and a marker `in_sof` that tags the first overhead byte of a frame. That byte is the first A1 byte. The serial port has four outputs: a clock (`ser_clk`), a data line (`ser_data`), a valid strobe (`ser_valid`) and a frame indicator (`ser_frame`).

The serial clock is derived from the core clock and runs at a period of `2*HALF` core cycles. All three serial outputs change only on the falling edge of `ser_clk`, so a receiver samples them on the rising edge. Overhead bytes arrive in bursts of a full row, much faster than they can be shifted out. A FIFO of `DEPTH` entries absorbs a burst. Bytes leave the FIFO most significant bit first.

`in_ready` is the back-pressure output and is high while the FIFO has room. The source of a received line cannot stall, so a byte offered while `in_ready` is low is not held back. It is dropped, and the sticky `overflow` flag is set. Only bytes with both `in_valid` and `in_toh` high are offered to the FIFO.

Top module: `toh_serial_port`

## Requirements
- R1: During and right after a synchronous reset, `ser_data`, `ser_valid`, `ser_frame` and `overflow` are 0 and `in_ready` is 1.
- R2: Every accepted overhead byte is sent in arrival order, most significant bit first, as 8 consecutive serial periods with `ser_valid` high. A byte is accepted when `in_valid`, `in_toh` and `in_ready` are high at a core clock edge and the block is synchronized.
- R3: `ser_valid` is high only in serial periods that carry an overhead bit. Whenever `ser_valid` is low, `ser_data` is 0.
- R4: `ser_data`, `ser_valid` and `ser_frame` change only at the core clock edge where `ser_clk` goes from 1 to 0. They are stable across each rising edge of `ser_clk`.
- R5: `ser_frame` is high for exactly one serial period, and `ser_valid` is low during that period. The next period carries the first bit of the byte marked by `in_sof`.
- R6: Bytes with `in_valid` low or `in_toh` low are never stored or sent.
- R7: After reset, overhead bytes are discarded until the first byte with `in_sof` high is offered. That byte is the first one accepted.
- R8: `in_ready` is 0 while the FIFO holds `DEPTH` bytes. An overhead byte offered while the FIFO is full is dropped and sets `overflow`, which stays 1 until reset.
- R9: `ser_clk` has a period of `2*HALF` core cycles: it is high for `HALF` cycles and then low for `HALF` cycles, repeating from reset.
- R10: `ser_frame` never pulses unless the next byte to be sent carries the frame-start mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte qualifier |
| in_ready | output | 1 | FIFO has room for an overhead byte |
| in_data | input | 8 | Input byte |
| in_toh | input | 1 | Byte is transport overhead |
| in_sof | input | 1 | Byte is the first overhead byte of a frame |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial overhead data, MSB first |
| ser_valid | output | 1 | Serial data carries an overhead bit |
| ser_frame | output | 1 | One-period frame indicator before the first bit |
| overflow | output | 1 | Sticky: an overhead byte was dropped on a full FIFO |

## Verification
The bench builds the block with `HALF=2` and `DEPTH=36`. Each serial bit then spans only four core cycles, so two complete frames of 324 overhead bytes fit into a short run. It drives full 36-byte row bursts with random spacing, separated by payload gaps just long enough to drain the FIFO. A final burst of 45 back-to-back bytes drives the FIFO to full, which makes the refusal path, the dropped bytes and the sticky flag observable.

// File: rtl/toh_pkg.sv
package toh_pkg;
  typedef struct packed {
    logic       sof;
    logic [7:0] data;
  } toh_byte_t;
endpackage

// File: rtl/toh_clkgen.sv
module toh_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic ser_clk,
  output logic fall_tick
);
  localparam int W = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam logic [W-1:0] LAST  = W'(2 * HALF - 1);
  localparam logic [W-1:0] FALLC = W'(HALF - 1);
  localparam logic [W-1:0] HALFC = W'(HALF);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign ser_clk   = (cnt_q < HALFC);
  assign fall_tick = (cnt_q == FALLC);

  // R9
  clk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    fall_tick |=> !ser_clk);
endmodule

// File: rtl/toh_fifo.sv
module toh_fifo import toh_pkg::*; #(
  parameter int DEPTH = 36
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  toh_byte_t wdata,
  input  logic      pop,
  output toh_byte_t head,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);
  localparam logic [CW-1:0] DEPC  = CW'(DEPTH);

  toh_byte_t mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == DEPC);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LASTP) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LASTP) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    full && !do_pop |=> full);
endmodule

// File: rtl/toh_serializer.sv
module toh_serializer import toh_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      empty,
  input  toh_byte_t head,
  output logic      pop,
  output logic      ser_data,
  output logic      ser_valid,
  output logic      ser_frame
);
  logic [7:0] shreg_q;
  logic [2:0] left_q;
  logic       busy_q;
  logic       announced_q;
  logic       between, announce;

  assign between  = !busy_q || (left_q == 3'd0);
  assign announce = tick && between && !empty && head.sof && !announced_q;
  assign pop      = tick && between && !empty && !(head.sof && !announced_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q     <= '0;
      left_q      <= '0;
      busy_q      <= 1'b0;
      announced_q <= 1'b0;
      ser_data    <= 1'b0;
      ser_valid   <= 1'b0;
      ser_frame   <= 1'b0;
    end else if (tick) begin
      if (!between) begin
        ser_data  <= shreg_q[7];
        shreg_q   <= {shreg_q[6:0], 1'b0};
        left_q    <= left_q - 1'b1;
        ser_valid <= 1'b1;
        ser_frame <= 1'b0;
      end else if (announce) begin
        busy_q      <= 1'b0;
        announced_q <= 1'b1;
        ser_data    <= 1'b0;
        ser_valid   <= 1'b0;
        ser_frame   <= 1'b1;
      end else if (pop) begin
        busy_q      <= 1'b1;
        announced_q <= 1'b0;
        ser_data    <= head.data[7];
        shreg_q     <= {head.data[6:0], 1'b0};
        left_q      <= 3'd7;
        ser_valid   <= 1'b1;
        ser_frame   <= 1'b0;
      end else begin
        busy_q    <= 1'b0;
        ser_data  <= 1'b0;
        ser_valid <= 1'b0;
        ser_frame <= 1'b0;
      end
    end
  end

  // R4
  outputs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({ser_data, ser_valid, ser_frame}));
  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_valid |-> !ser_data);
  // R5
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ser_frame |-> !ser_valid);
  // R5
  frame_then_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ser_frame && tick |=> ser_valid);
endmodule

// File: rtl/toh_serial_port.sv
module toh_serial_port import toh_pkg::*; #(
  parameter int HALF  = 2,
  parameter int DEPTH = 36
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_toh,
  input  logic       in_sof,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_valid,
  output logic       ser_frame,
  output logic       overflow
);
  logic      fall_tick, synced_q, offer, push, pop, empty, full;
  toh_byte_t head, wbyte;

  toh_clkgen #(.HALF(HALF)) u_clk (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .fall_tick(fall_tick)
  );

  assign offer     = in_valid && in_toh && (synced_q || in_sof);
  assign push      = offer && !full;
  assign in_ready  = !full;
  assign wbyte.sof  = in_sof;
  assign wbyte.data = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      synced_q <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (in_valid && in_toh && in_sof) synced_q <= 1'b1;
      if (offer && full) overflow <= 1'b1;
    end
  end

  toh_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(wbyte), .pop(pop),
    .head(head), .empty(empty), .full(full)
  );

  toh_serializer u_ser (
    .clk(clk), .rst(rst), .tick(fall_tick), .empty(empty), .head(head),
    .pop(pop), .ser_data(ser_data), .ser_valid(ser_valid), .ser_frame(ser_frame)
  );

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R8
  full_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    offer && !in_ready |=> overflow);
endmodule

// File: tb/test_toh_serial_port.sv
module test_toh_serial_port;
  localparam int HALF = 2;
  localparam int DEPTH = 36;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_toh = 0, in_sof = 0;
  logic [7:0] in_data = 0;
  logic in_ready, ser_clk, ser_data, ser_valid, ser_frame, overflow;

  always #5 clk = ~clk;

  toh_serial_port #(.HALF(HALF), .DEPTH(DEPTH)) i_toh_serial_port (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_toh(in_toh), .in_sof(in_sof), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_valid(ser_valid), .ser_frame(ser_frame),
    .overflow(overflow)
  );

  int checks = 0, fails = 0;
  logic [8:0] q[$];
  bit synced_m = 0;
  bit saw_not_ready = 0;
  int bits_seen = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(int row, int col);
    if (row == 0 && col < 12) return 8'hF6;
    if (row == 0 && col < 24) return 8'h28;
    return 8'($urandom);
  endfunction

  task automatic drive(bit v, bit t, bit s, logic [7:0] d);
    @(negedge clk);
    in_valid = v; in_toh = t; in_sof = s; in_data = d;
    if (v && t && (synced_m || s)) begin
      if (in_ready) q.push_back({s, d});
      else saw_not_ready = 1;
    end
    if (v && t && s) synced_m = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'($urandom), 1'b0, 1'b0, 8'($urandom));
  endtask

  // monitor: sample on rising edges of ser_clk, away from core edges
  logic prev_clk = 1'b1;
  logic [2:0] prev_out = '0;
  bit prev_frame = 0;
  int bitcnt = 0, since_rise = 0;
  bit rose_once = 0;
  logic [7:0] acc;
  always @(negedge clk) begin
    if (!rst) begin
      if ({ser_data, ser_valid, ser_frame} != prev_out)
        check(prev_clk && !ser_clk, "R4", "output change off falling edge", int'(ser_clk), 0);
      since_rise++;
      if (ser_clk && !prev_clk) begin
        if (rose_once) check(since_rise == 2 * HALF, "R9", "serial period", since_rise, 2 * HALF);
        rose_once = 1;
        since_rise = 0;
        if (ser_frame) begin
          check(!ser_valid, "R5", "valid during frame", int'(ser_valid), 0);
          check(q.size() > 0 && bitcnt == 0 && q[0][8], "R10", "frame without pending start", 0, 1);
        end else if (ser_valid) begin
          bits_seen++;
          if (bitcnt == 0) begin
            check(q.size() > 0, "R3", "valid with nothing queued", q.size(), 1);
            if (q.size() > 0)
              check(q[0][8] == prev_frame, "R5", "frame lead before start byte", int'(prev_frame), int'(q[0][8]));
          end
          acc = {acc[6:0], ser_data};
          bitcnt++;
          if (bitcnt == 8) begin
            if (q.size() > 0) begin
              check(acc == q[0][7:0], "R2", "serial byte", acc, q[0][7:0]);
              void'(q.pop_front());
            end
            bitcnt = 0;
          end
        end else begin
          check(!ser_data, "R3", "data while idle", int'(ser_data), 0);
          check(bitcnt == 0, "R2", "gap inside byte", bitcnt, 0);
        end
        prev_frame = ser_frame;
      end
    end
    prev_clk = ser_clk;
    prev_out = {ser_data, ser_valid, ser_frame};
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; in_toh = 0; in_sof = 0;
    repeat (3) @(negedge clk);
    check(!ser_data && !ser_valid && !ser_frame, "R1", "serial outputs in reset", {ser_data, ser_valid, ser_frame}, 0);
    rst = 0;
    synced_m = 0; q.delete(); bitcnt = 0; prev_frame = 0; rose_once = 0;
    prev_clk = 1'b1; prev_out = '0;
    @(negedge clk);
    check(!ser_data && !ser_valid && !ser_frame, "R1", "serial outputs after reset", {ser_data, ser_valid, ser_frame}, 0);
    check(!overflow, "R1", "overflow after reset", int'(overflow), 0);
    check(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() > 0 || bitcnt != 0) && n < 4000) begin @(negedge clk); n++; end
    repeat (8 * HALF) @(negedge clk);
    check(q.size() == 0, "R2", "bytes never sent", q.size(), 0);
  endtask

  bit wd = 0;
  initial begin
    void'($urandom(32'd1234));
    fork
      begin
        do_reset();
        // R7: overhead bytes before any frame start are discarded
        for (int i = 0; i < 6; i++) drive(1, 1, 0, 8'hA5);
        idle(200);
        check(bits_seen == 0, "R7", "bits sent before sync", bits_seen, 0);
        // R2/R5/R6: two frames of row bursts with payload gaps
        for (int f = 0; f < 2; f++)
          for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < 36; c++) begin
              if ($urandom % 2 == 0) drive(1'($urandom), 1'b0, 1'b0, 8'($urandom));
              drive(1, 1, (r == 0 && c == 0), frame_byte(r, c));
            end
            idle(1300);
          end
        drain();
        check(bits_seen == 2 * 324 * 8, "R6", "total bits of two frames", bits_seen, 2 * 324 * 8);
        check(!overflow, "R8", "overflow without full fifo", int'(overflow), 0);
        // R8: burst beyond depth
        drive(1, 1, 1, 8'hF6);
        for (int i = 0; i < 44; i++) drive(1, 1, 0, 8'(i + 3));
        drive(0, 0, 0, 8'h00);
        check(saw_not_ready, "R8", "in_ready never low on full", int'(saw_not_ready), 1);
        check(overflow, "R8", "overflow after dropped byte", int'(overflow), 1);
        drain();
        check(overflow, "R8", "overflow sticky", int'(overflow), 1);
        do_reset();
      end
      begin
        repeat (190000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) check(0, "R2", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule